// File: doc/BRIEF.md
# Software write-protect sequence detector

This block sits beside the page-load logic of a parallel byte-wide nonvolatile memory. It watches every accepted write cycle, given as an address, a data byte and a valid strobe, and decides for each one whether the byte may enter the page buffer. It also holds the protection state. The state is treated as persistent: it is a register with an initial-value parameter, and the block reset does not clear it. A separate pulse marks the end of each page load, which is when the internal programming cycle completes. Protection changes only on that pulse.

Three command writes at fixed addresses form an unlock prefix. After the prefix, every further write in the same page load is accepted, even when the memory is protected, and protection is set when the load ends. A longer six-write command sequence arms protection removal, and protection drops when the load ends. The command writes themselves never reach the page buffer. A write that breaks a sequence sends the detector back to idle. That write is then judged as a fresh write, so it can start a new sequence.

If a write arrives in the same cycle as the end-of-load pulse, its permit is judged in the usual way, but its sequence step is dropped.

Top module: `sdp_guard`

## Requirements
- R1: After power-up, `protect_on` equals the INIT_PROT parameter, which defaults to 0 (unprotected).
- R2: While unprotected and idle, a write that is not a command step raises `wr_permit` in the same cycle.
- R3: While protected, a write outside an unlocked page load gets `wr_permit` low.
- R4: The unlock prefix is data 8'hAA to address 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. Each of these command writes has `wr_permit` low. Every later write in the same page load has `wr_permit` high, whatever the protection state.
- R5: When `cycle_done` pulses after a completed unlock prefix, `protect_on` is 1 from the next cycle onward.
- R6: The disable sequence is 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h80@15'h5555, 8'hAA@15'h5555, 8'h55@15'h2AAA, 8'h20@15'h5555. Protection stays set, and later writes in that load are judged as protected, until `cycle_done`. From the next cycle `protect_on` is 0.
- R7: A write that does not match the expected next step returns the detector to idle. That write is then judged from idle: it starts a new sequence if it is the first step, and otherwise gets `wr_permit` equal to the inverse of `protect_on`.
- R8: Matching uses all 15 address bits and all 8 data bits. A difference in any single bit makes the write a plain write.
- R9: `cycle_done` returns the detector to idle, so a sequence split across two page loads does not take effect.
- R10: `rst_n` clears the detector's progress but leaves `protect_on` unchanged.
- R11: `wr_permit` is low in any cycle without `wr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequence detector |
| wr_valid | input | 1 | An accepted write cycle is present this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| cycle_done | input | 1 | One-cycle pulse: the current page load has completed |
| wr_permit | output | 1 | This write may enter the page buffer |
| protect_on | output | 1 | Current protection state |

## Verification
The bound checker enforces the following on every cycle:
- no permit without a valid write;
- no permitted write while protected, except in an unlocked load;
- protection moves only on an end-of-load pulse, and only in the direction the armed sequence asks for;
- the detector is idle after every end-of-load pulse.

Only the bench scenarios can show the rest: exact command values and single-bit mismatches, abort-and-restart behaviour, sequences split across loads, and protection surviving reset. The bench covers these with directed cases and with a reference model run under random write streams biased toward the command values.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // Detector progress. OPEN: unlock prefix seen. SHUT: disable sequence seen.
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_OPEN, SQ_D3, SQ_D4, SQ_D5, SQ_SHUT
  } sq_t;
endpackage

// File: rtl/sdp_step.sv
module sdp_step
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A1 = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_A2 = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_LEAD = 8'hAA,
  parameter logic [DATA_W-1:0] D_SEC  = 8'h55,
  parameter logic [DATA_W-1:0] D_ARM  = 8'hA0,
  parameter logic [DATA_W-1:0] D_ERA  = 8'h80,
  parameter logic [DATA_W-1:0] D_OFF  = 8'h20
) (
  input  sq_t               cur,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output sq_t               nxt,
  output logic              cmd_hit
);
  function automatic logic key_eq(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                  input logic [ADDR_W-1:0] ka, input logic [DATA_W-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction

  logic lead_w, sec_w, arm_w, era_w, off_w;
  assign lead_w = key_eq(addr, data, KEY_A1, D_LEAD);
  assign sec_w  = key_eq(addr, data, KEY_A2, D_SEC);
  assign arm_w  = key_eq(addr, data, KEY_A1, D_ARM);
  assign era_w  = key_eq(addr, data, KEY_A1, D_ERA);
  assign off_w  = key_eq(addr, data, KEY_A1, D_OFF);

  sq_t restart_w;
  assign restart_w = lead_w ? SQ_K1 : SQ_IDLE;

  always_comb begin
    nxt     = restart_w;
    cmd_hit = lead_w;
    unique case (cur)
      SQ_IDLE: ;
      SQ_K1:   if (sec_w) begin nxt = SQ_K2; cmd_hit = 1'b1; end
      SQ_K2: begin
        if (arm_w)      begin nxt = SQ_OPEN; cmd_hit = 1'b1; end
        else if (era_w) begin nxt = SQ_D3;   cmd_hit = 1'b1; end
      end
      SQ_D3:   if (lead_w) begin nxt = SQ_D4; cmd_hit = 1'b1; end
      SQ_D4:   if (sec_w)  begin nxt = SQ_D5; cmd_hit = 1'b1; end
      SQ_D5:   if (off_w)  begin nxt = SQ_SHUT; cmd_hit = 1'b1; end
      SQ_OPEN, SQ_SHUT: begin nxt = cur; cmd_hit = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdp_latch.sv
module sdp_latch #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic set_val,
  output logic q
);
  // Persistent state: initial value only, no reset term.
  logic q_r = INIT;
  always_ff @(posedge clk) begin
    if (rst_n && load) q_r <= set_val;
  end
  assign q = q_r;
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
  import sdp_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter logic INIT_PROT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cycle_done,
  output logic              wr_permit,
  output logic              protect_on
);
  sq_t  seq_q, seq_nx;
  logic cmd_hit;

  sdp_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step (
    .cur(seq_q), .addr(wr_addr), .data(wr_data), .nxt(seq_nx), .cmd_hit(cmd_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seq_q <= SQ_IDLE;
    else if (cycle_done) seq_q <= SQ_IDLE;
    else if (wr_valid)   seq_q <= seq_nx;
  end

  // Named events for the checker
  logic seq_idle, seq_open, seq_shut, prot_load;
  assign seq_idle  = (seq_q == SQ_IDLE);
  assign seq_open  = (seq_q == SQ_OPEN);
  assign seq_shut  = (seq_q == SQ_SHUT);
  assign prot_load = cycle_done && (seq_open || seq_shut);

  sdp_latch #(.INIT(INIT_PROT)) u_prot (
    .clk(clk), .rst_n(rst_n), .load(prot_load), .set_val(seq_open), .q(protect_on)
  );

  assign wr_permit = wr_valid && (seq_open || (!cmd_hit && !protect_on));
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic cycle_done,
  input logic wr_permit,
  input logic protect_on,
  input logic seq_idle,
  input logic seq_open,
  input logic seq_shut
);
  // R11
  permit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> !wr_permit);
  // R3
  protected_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_on && wr_permit) |-> seq_open);
  // R9
  done_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> seq_idle);
  // R6
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable(protect_on));
  // R5
  prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_on) |-> $past(cycle_done && seq_open));
  // R6
  prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_on) |-> $past(cycle_done && seq_shut));
endmodule

bind sdp_guard sdp_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cycle_done(cycle_done),
  .wr_permit(wr_permit), .protect_on(protect_on),
  .seq_idle(seq_idle), .seq_open(seq_open), .seq_shut(seq_shut)
);

// File: tb/sim_sdp_guard.sv
module sim_sdp_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cycle_done = 1'b0;
  logic wr_permit, protect_on;

  int n_chk = 0;
  int n_bad = 0;
  int ms = 0;       // model step: 0 idle,1,2,3 open,4,5,6,7 armed-off
  bit mprot = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdp_guard u0 (.clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
                .wr_data(wr_data), .cycle_done(cycle_done), .wr_permit(wr_permit),
                .protect_on(protect_on));

  localparam logic [22:0] W_LEAD = {15'h5555, 8'hAA};
  localparam logic [22:0] W_SEC  = {15'h2AAA, 8'h55};
  localparam logic [22:0] W_ARM  = {15'h5555, 8'hA0};
  localparam logic [22:0] W_ERA  = {15'h5555, 8'h80};
  localparam logic [22:0] W_OFF  = {15'h5555, 8'h20};

  // returns {cmd, next_step}
  function automatic logic [3:0] m_next(int st, logic [22:0] w);
    logic [3:0] rs;
    rs = (w == W_LEAD) ? 4'b1_001 : 4'b0_000;
    case (st)
      0: return rs;
      1: return (w == W_SEC) ? 4'b1_010 : rs;
      2: return (w == W_ARM) ? 4'b1_011 : (w == W_ERA) ? 4'b1_100 : rs;
      4: return (w == W_LEAD) ? 4'b1_101 : rs;
      5: return (w == W_SEC) ? 4'b1_110 : rs;
      6: return (w == W_OFF) ? 4'b1_111 : rs;
      default: return {1'b0, 3'(st)};
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d, string req);
    logic [3:0] r;
    bit exp;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    r = m_next(ms, {a, d});
    exp = (ms == 3) || (!r[3] && !mprot);
    #1;
    check(wr_permit == exp, req, wr_permit, exp);
    @(posedge clk);
    ms = int'(r[2:0]);
    #1 wr_valid = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    cycle_done = 1'b1;
    @(posedge clk);
    if (ms == 3) mprot = 1'b1;
    if (ms == 7) mprot = 1'b0;
    ms = 0;
    #1 cycle_done = 1'b0;
  endtask

  task automatic chk_prot(bit exp, string req);
    @(negedge clk);
    check(protect_on == exp && mprot == exp, req, protect_on, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    ms = 0;
  endtask

  task automatic prefix(string req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'hA0, req);
  endtask

  task automatic disable_seq(string req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'h80, req);
    wr(15'h5555, 8'hAA, req); wr(15'h2AAA, 8'h55, req); wr(15'h5555, 8'h20, req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7261));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state, R11 idle permit
    chk_prot(1'b0, "R1");
    #1 check(wr_permit == 1'b0, "R11", wr_permit, 0);
    // R2 plain write while unprotected
    wr(15'h1234, 8'h5A, "R2");
    // R4 unlock prefix, then data accepted; R5 protection set at done
    prefix("R4");
    wr(15'h0100, 8'h11, "R4");
    chk_prot(1'b0, "R5");
    done();
    chk_prot(1'b1, "R5");
    // R3 protected plain write blocked
    wr(15'h0200, 8'h22, "R3");
    // R4 unlock while protected
    prefix("R4"); wr(15'h0300, 8'h33, "R4"); wr(15'h0301, 8'h34, "R4");
    done(); chk_prot(1'b1, "R5");
    // R8 single-bit address and data mismatches
    wr(15'h5555 ^ 15'h4000, 8'hAA, "R8"); wr(15'h2AAA, 8'h55, "R8");
    wr(15'h5555, 8'hA0, "R8"); wr(15'h0400, 8'h44, "R8");
    wr(15'h5555, 8'hAB, "R8"); wr(15'h0401, 8'h45, "R8");
    done();
    // R9 prefix split across loads
    wr(15'h5555, 8'hAA, "R9"); wr(15'h2AAA, 8'h55, "R9"); done();
    wr(15'h5555, 8'hA0, "R9"); wr(15'h0500, 8'h55, "R9"); done();
    // R7 abort while protected, then restart works
    wr(15'h5555, 8'hAA, "R7"); wr(15'h2AAA, 8'h12, "R7"); wr(15'h5555, 8'hA0, "R7");
    wr(15'h0600, 8'h66, "R7");
    wr(15'h5555, 8'hAA, "R7"); wr(15'h5555, 8'hAA, "R7"); wr(15'h2AAA, 8'h55, "R7");
    wr(15'h5555, 8'hA0, "R7"); wr(15'h0601, 8'h67, "R7"); done();
    // R6 disable: still protected until done
    disable_seq("R6");
    wr(15'h0700, 8'h77, "R6");
    chk_prot(1'b1, "R6");
    done();
    chk_prot(1'b0, "R6");
    wr(15'h0701, 8'h78, "R6");
    // R7 abort while unprotected: breaking write passes
    wr(15'h5555, 8'hAA, "R7"); wr(15'h0042, 8'h77, "R7"); done();
    // R10 reset keeps protection, clears progress
    prefix("R10"); done(); chk_prot(1'b1, "R10");
    do_reset(); chk_prot(1'b1, "R10");
    wr(15'h0800, 8'h88, "R10");
    wr(15'h5555, 8'hAA, "R10"); wr(15'h2AAA, 8'h55, "R10");
    do_reset();
    wr(15'h5555, 8'hA0, "R10"); wr(15'h0801, 8'h89, "R10");
    done(); chk_prot(1'b1, "R10");
    // Random streams biased to command values
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [14:0] a;
      logic [7:0] d;
      op = $urandom_range(0, 9);
      if (op == 0) begin
        done();
        chk_prot(mprot, "R5");
      end else begin
        case ($urandom_range(0, 2))
          0: a = 15'h5555;
          1: a = 15'h2AAA;
          default: a = 15'($urandom);
        endcase
        case ($urandom_range(0, 5))
          0: d = 8'hAA;
          1: d = 8'h55;
          2: d = 8'hA0;
          3: d = 8'h80;
          4: d = 8'h20;
          default: d = 8'($urandom);
        endcase
        wr(a, d, ms == 3 ? "R4" : mprot ? "R3" : "R2");
      end
    end
    finish_run();
  end
endmodule